// File: doc/BRIEF.md
# Packet-Filter VM Branch Resolver

This block settles the control-flow outcome of one jump-class instruction for a packet-filter virtual machine. It takes the 8-bit opcode, the instruction's 4-bit source-register field, the destination operand, the source operand, the 16-bit signed offset and the current program counter. The caller supplies the source operand already resolved: either a register value or the sign-extended immediate. The program counter counts 64-bit instruction slots. From these inputs the block reports whether the branch is taken, the next program counter, whether the instruction is a call or a return, and which kind of call it is. It raises an illegal flag for encodings that have no meaning.

The opcode holds the operation in bits 7:4, the source-select flag in bit 3 and the class in bits 2:0. Class 5 compares the full operands and class 6 compares only their low halves. The block registers its result once, so the answer for an instruction presented with `in_valid` appears one clock later with `out_valid`. The caller carries out calls and returns.

Top module: `bfr_branch_resolver`

## Requirements
- R1: While reset is held, and after it until the first accepted instruction, `out_valid`, `taken`, `is_call`, `is_exit` and `illegal` are 0, and `next_pc` and `call_kind` are 0.
- R2: Results appear exactly one clock after the instruction is presented. `out_valid` in a cycle equals `in_valid` of the cycle before.
- R3: Class 5 (opcode bits 2:0 = 5) compares the full DATA_W-bit operands. Class 6 compares only the low DATA_W/2 bits and ignores the upper halves, including for sign.
- R4: Code 1 is taken when the operands are equal. Code 5 is taken when they differ. Code 4 is taken when their bitwise AND is nonzero.
- R5: Unsigned compares: code 2 is taken on dst > src, code 3 on dst >= src, code 0xa on dst < src, and code 0xb on dst <= src.
- R6: Signed two's-complement compares: code 6 is taken on >, code 7 on >=, code 0xc on <, and code 0xd on <=.
- R7: A taken instruction gives next_pc = pc + 1 + sign-extended offset, modulo 2^PC_W. Every other instruction gives next_pc = pc + 1.
- R8: Code 0 in class 5 is always taken.
- R9: Code 8 is a call. `call_kind` takes the source-register field: 0 is a helper by address, 1 is a local function, 2 is a helper by type ID. Only a local call is taken. `is_call` is 1 for all three kinds.
- R10: Code 9 in class 5 sets `is_exit` and is not taken.
- R11: The following raise `illegal`: a class other than 5 or 6; code 0 or 9 in class 6; codes 0xe and 0xf; a call whose source field is greater than 2; and code 0, 8 or 9 with opcode bit 3 set. An illegal instruction has `taken`, `is_call` and `is_exit` at 0, `call_kind` at 0, and next_pc = pc + 1.
- R12: Opcode 0x7e is a signed >= compare on the low halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode |
| src_field | input | 4 | Source-register field of the instruction (call subtype) |
| dst_val | input | DATA_W | Destination operand |
| src_val | input | DATA_W | Source operand (register or sign-extended immediate) |
| offset | input | OFF_W | Signed branch offset in instruction slots |
| pc | input | PC_W | Current program counter |
| out_valid | output | 1 | Result registers hold a new result |
| taken | output | 1 | Control transfers to the branch target |
| next_pc | output | PC_W | Program counter of the next instruction |
| is_call | output | 1 | Instruction is a call |
| call_kind | output | 2 | 0 helper by address, 1 local, 2 helper by type ID |
| is_exit | output | 1 | Instruction is a return |
| illegal | output | 1 | Encoding is not valid |

## Verification
The bench builds the block with its defaults: 64-bit operands, a 32-bit program counter and a 16-bit offset. With these values the narrow class works on 32-bit halves. The bench can then flip only the upper half of an operand and show that the narrow compare ignores it. A 32-bit program counter is small enough to place near 0 and near its top, so the bench reaches target wrap-around in both directions with offsets of either sign. The random operands are skewed toward equal values and values that differ only in the upper half, so the boundaries between equal, less and greater are hit often.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  typedef enum logic [3:0] {
    BR_ALWAYS = 4'h0,
    BR_EQ     = 4'h1,
    BR_UGT    = 4'h2,
    BR_UGE    = 4'h3,
    BR_ANYSET = 4'h4,
    BR_NE     = 4'h5,
    BR_SGT    = 4'h6,
    BR_SGE    = 4'h7,
    BR_CALL   = 4'h8,
    BR_RET    = 4'h9,
    BR_ULT    = 4'ha,
    BR_ULE    = 4'hb,
    BR_SLT    = 4'hc,
    BR_SLE    = 4'hd,
    BR_RSV_E  = 4'he,
    BR_RSV_F  = 4'hf
  } br_code_e;

  typedef enum logic [1:0] {
    CK_HELPER_ADDR = 2'd0,
    CK_LOCAL       = 2'd1,
    CK_HELPER_ID   = 2'd2
  } call_kind_e;

  // Every condition is built from four primitive relations.
  function automatic logic cond_eval(input br_code_e code, input logic eq,
                                     input logic ult, input logic slt,
                                     input logic any_set);
    logic hit;
    case (code)
      BR_EQ:     hit = eq;
      BR_NE:     hit = !eq;
      BR_ANYSET: hit = any_set;
      BR_UGT:    hit = !ult && !eq;
      BR_UGE:    hit = !ult;
      BR_ULT:    hit = ult;
      BR_ULE:    hit = ult || eq;
      BR_SGT:    hit = !slt && !eq;
      BR_SGE:    hit = !slt;
      BR_SLT:    hit = slt;
      BR_SLE:    hit = slt || eq;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/bfr_decode.sv
module bfr_decode
  import bfr_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [3:0] src_field,
  output br_code_e   code,
  output logic       narrow,
  output logic       is_always,
  output logic       is_cond,
  output logic       is_call,
  output call_kind_e call_kind,
  output logic       is_exit,
  output logic       illegal
);

  logic [2:0] cls;
  logic       src_sel;
  logic       bad;

  assign cls     = opcode[2:0];
  assign src_sel = opcode[3];
  assign code    = br_code_e'(opcode[7:4]);
  assign narrow  = (cls == CLS_NARROW);

  always_comb begin
    bad       = (cls != CLS_WIDE) && (cls != CLS_NARROW);
    is_always = 1'b0;
    is_cond   = 1'b0;
    is_call   = 1'b0;
    is_exit   = 1'b0;
    call_kind = CK_HELPER_ADDR;
    case (code)
      BR_ALWAYS: begin
        if (narrow || src_sel) bad = 1'b1;
        else                   is_always = 1'b1;
      end
      BR_RET: begin
        if (narrow || src_sel) bad = 1'b1;
        else                   is_exit = 1'b1;
      end
      BR_CALL: begin
        if (src_sel || (src_field > 4'd2)) bad = 1'b1;
        else begin
          is_call   = 1'b1;
          call_kind = call_kind_e'(src_field[1:0]);
        end
      end
      BR_RSV_E, BR_RSV_F: bad = 1'b1;
      default: is_cond = 1'b1;
    endcase
    if (bad) begin
      is_always = 1'b0;
      is_cond   = 1'b0;
      is_call   = 1'b0;
      is_exit   = 1'b0;
      call_kind = CK_HELPER_ADDR;
    end
    illegal = bad;
  end

endmodule

// File: rtl/bfr_compare.sv
module bfr_compare #(
  parameter int DATA_W = 64
) (
  input  logic              narrow,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              eq,
  output logic              ult,
  output logic              slt,
  output logic              any_set
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [3:0] relate_wide(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    return {x == y, x < y, $signed(x) < $signed(y), |(x & y)};
  endfunction

  function automatic logic [3:0] relate_half(input logic [HALF_W-1:0] x,
                                              input logic [HALF_W-1:0] y);
    return {x == y, x < y, $signed(x) < $signed(y), |(x & y)};
  endfunction

  logic [3:0] rel_wide;
  logic [3:0] rel_half;

  assign rel_wide = relate_wide(a, b);
  assign rel_half = relate_half(a[HALF_W-1:0], b[HALF_W-1:0]);

  assign {eq, ult, slt, any_set} = narrow ? rel_half : rel_wide;

endmodule

// File: rtl/bfr_target.sv
module bfr_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  jump_pc
);

  localparam int EXT_W = PC_W - OFF_W;

  function automatic logic [PC_W-1:0] widen(input logic [OFF_W-1:0] off);
    return {{EXT_W{off[OFF_W-1]}}, off};
  endfunction

  assign seq_pc  = pc + PC_W'(1);
  assign jump_pc = seq_pc + widen(offset);

endmodule

// File: rtl/bfr_branch_resolver.sv
module bfr_branch_resolver
  import bfr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [3:0]        src_field,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PC_W-1:0]   pc,
  output logic              out_valid,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic              is_call,
  output logic [1:0]        call_kind,
  output logic              is_exit,
  output logic              illegal
);

  localparam int EXT_W = PC_W - OFF_W;

  br_code_e   dec_code;
  logic       dec_narrow, dec_always, dec_cond, dec_call, dec_exit, dec_illegal;
  call_kind_e dec_kind;
  logic       rel_eq, rel_ult, rel_slt, rel_any;
  logic [PC_W-1:0] seq_pc, jump_pc;
  logic       cond_hit, local_call, take_now;
  logic [PC_W-1:0] pc_now;

  bfr_decode u_decode (
    .opcode    (opcode),
    .src_field (src_field),
    .code      (dec_code),
    .narrow    (dec_narrow),
    .is_always (dec_always),
    .is_cond   (dec_cond),
    .is_call   (dec_call),
    .call_kind (dec_kind),
    .is_exit   (dec_exit),
    .illegal   (dec_illegal)
  );

  bfr_compare #(.DATA_W(DATA_W)) u_compare (
    .narrow  (dec_narrow),
    .a       (dst_val),
    .b       (src_val),
    .eq      (rel_eq),
    .ult     (rel_ult),
    .slt     (rel_slt),
    .any_set (rel_any)
  );

  bfr_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc      (pc),
    .offset  (offset),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  // Named internal events, kept visible for the assertions.
  assign cond_hit   = dec_cond && cond_eval(dec_code, rel_eq, rel_ult, rel_slt, rel_any);
  assign local_call = dec_call && (dec_kind == CK_LOCAL);
  assign take_now   = dec_always || cond_hit || local_call;
  assign pc_now     = take_now ? jump_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      is_call   <= 1'b0;
      call_kind <= 2'd0;
      is_exit   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken     <= take_now;
        next_pc   <= pc_now;
        is_call   <= dec_call;
        call_kind <= dec_kind;
        is_exit   <= dec_exit;
        illegal   <= dec_illegal;
      end
    end
  end

  // R2: the result follows the presented instruction by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: sequential and branch targets measured from the presented pc
  a_r7_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> (next_pc == $past(pc) + PC_W'(1)));
  a_r7_jump_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && taken) |->
      (next_pc == $past(pc) + PC_W'(1) + {{EXT_W{$past(offset[OFF_W-1])}}, $past(offset)}));

  // R11: an illegal encoding has no other effect
  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (!taken && !is_call && !is_exit));

  // R9: only the local call kind moves control
  a_r9_helper_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_call && call_kind != 2'd1) |-> !taken);

  // R10: a return comes only from code 9 in the wide class with bit 3 clear
  a_r10_exit_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_exit) |-> ($past(opcode) == 8'h95 && !taken));

  // R11: at most one kind of outcome per result
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({illegal, is_call, is_exit}));

endmodule

// File: tb/bfr_branch_resolver_tb.sv
module bfr_branch_resolver_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [3:0]  src_field;
  logic [63:0] dst_val, src_val;
  logic [15:0] offset;
  logic [31:0] pc;
  logic        out_valid, taken, is_call, is_exit, illegal;
  logic [31:0] next_pc;
  logic [1:0]  call_kind;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfr_branch_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_field(src_field), .dst_val(dst_val), .src_val(src_val),
    .offset(offset), .pc(pc), .out_valid(out_valid), .taken(taken),
    .next_pc(next_pc), .is_call(is_call), .call_kind(call_kind),
    .is_exit(is_exit), .illegal(illegal)
  );

  // Expected outcome, packed {illegal, taken, is_call, kind[1:0], is_exit}
  function automatic logic [5:0] ref_flags(input logic [7:0] op, input logic [3:0] sf,
                                           input logic [63:0] d, input logic [63:0] s);
    logic [2:0] cls;
    logic [3:0] c;
    logic       nar, bad, tk, cl, ex;
    logic [1:0] kd;
    logic [63:0] ud, us;
    longint     sd, ss;
    cls = op[2:0]; c = op[7:4]; nar = (cls == 3'd6);
    bad = !(cls == 3'd5 || nar);
    tk = 0; cl = 0; ex = 0; kd = 0;
    ud = nar ? {32'd0, d[31:0]} : d;
    us = nar ? {32'd0, s[31:0]} : s;
    sd = nar ? longint'($signed(d[31:0])) : longint'($signed(d));
    ss = nar ? longint'($signed(s[31:0])) : longint'($signed(s));
    case (c)
      4'h0: if (nar || op[3]) bad = 1; else tk = 1;
      4'h1: tk = (ud == us);
      4'h5: tk = (ud != us);
      4'h4: tk = ((ud & us) != 0);
      4'h2: tk = (ud > us);
      4'h3: tk = (ud >= us);
      4'ha: tk = (ud < us);
      4'hb: tk = (ud <= us);
      4'h6: tk = (sd > ss);
      4'h7: tk = (sd >= ss);
      4'hc: tk = (sd < ss);
      4'hd: tk = (sd <= ss);
      4'h8: if (op[3] || sf > 2) bad = 1; else begin cl = 1; kd = sf[1:0]; tk = (sf == 1); end
      4'h9: if (nar || op[3]) bad = 1; else ex = 1;
      default: bad = 1;
    endcase
    if (bad) begin tk = 0; cl = 0; ex = 0; kd = 0; end
    return {bad, tk, cl, kd, ex};
  endfunction

  function automatic logic [31:0] ref_pc(input logic tk, input logic [31:0] p,
                                         input logic [15:0] off);
    int signed soff;
    soff = int'($signed(off));
    return tk ? p + 32'd1 + 32'(soff) : p + 32'd1;
  endfunction

  task automatic expect_bit(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Presents one instruction at a falling edge and checks the result one cycle later.
  task automatic run_one(input string tag, input logic [7:0] op, input logic [3:0] sf,
                         input logic [63:0] d, input logic [63:0] s,
                         input logic [15:0] off, input logic [31:0] p);
    logic [5:0]  ef;
    logic [31:0] epc;
    ef  = ref_flags(op, sf, d, s);
    epc = ref_pc(ef[4], p, off);
    in_valid = 1; opcode = op; src_field = sf; dst_val = d; src_val = s;
    offset = off; pc = p;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b1 || illegal !== ef[5] || taken !== ef[4] || is_call !== ef[3] ||
        call_kind !== ef[2:1] || is_exit !== ef[0] || next_pc !== epc) begin
      n_fails++;
      $display("FAIL %s op=%02h: actual v%0b il%0b tk%0b cl%0b k%0d ex%0b pc=%08h expected il%0b tk%0b cl%0b k%0d ex%0b pc=%08h",
               tag, op, out_valid, illegal, taken, is_call, call_kind, is_exit, next_pc,
               ef[5], ef[4], ef[3], ef[2:1], ef[0], epc);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op, input logic [3:0] sf);
    if (!(op[2:0] == 3'd5 || op[2:0] == 3'd6)) return "R11";
    case (op[7:4])
      4'h1, 4'h4, 4'h5:       return "R4";
      4'h2, 4'h3, 4'ha, 4'hb: return "R5";
      4'h6, 4'h7, 4'hc, 4'hd: return "R6";
      4'h0:                   return op[2:0] == 3'd5 && !op[3] ? "R8" : "R11";
      4'h8:                   return sf <= 2 && !op[3] ? "R9" : "R11";
      4'h9:                   return op[2:0] == 3'd5 && !op[3] ? "R10" : "R11";
      default:                return "R11";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b7f));
    rst_n = 0; in_valid = 0; opcode = 0; src_field = 0; dst_val = 0; src_val = 0;
    offset = 0; pc = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_bit("R1", "out_valid", out_valid, 0);
    expect_bit("R1", "taken", taken, 0);
    expect_bit("R1", "flags", is_call | is_exit | illegal | (|call_kind) | (|next_pc), 0);
    rst_n = 1;
    @(negedge clk);
    expect_bit("R1", "out_valid after release", out_valid, 0);

    // R3: upper halves differ, low halves equal
    run_one("R3", 8'h15, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 16'd7, 32'd100);
    run_one("R3", 8'h16, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 16'd7, 32'd100);
    run_one("R3", 8'h66, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 16'd3, 32'd10);
    run_one("R3", 8'h65, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 16'd3, 32'd10);
    // R4
    run_one("R4", 8'h45, 0, 64'h00F0, 64'h0F00, 16'd2, 32'd5);
    run_one("R4", 8'h4d, 0, 64'h01F0, 64'h0F00, 16'd2, 32'd5);
    run_one("R4", 8'h55, 0, 64'd9, 64'd9, 16'd2, 32'd5);
    // R5 / R6 boundary: all-ones versus one
    run_one("R5", 8'h25, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd4, 32'd20);
    run_one("R6", 8'h65, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd4, 32'd20);
    run_one("R5", 8'hb5, 0, 64'd1, 64'd1, 16'd4, 32'd20);
    run_one("R6", 8'hd5, 0, 64'd1, 64'd1, 16'd4, 32'd20);
    // R12: 0x7e signed >= on low halves
    run_one("R12", 8'h7e, 3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 16'd8, 32'd40);
    run_one("R12", 8'h7e, 3, 64'h0000_0000_0000_0005, 64'hFFFF_FFFF_0000_0005, 16'd8, 32'd40);
    // R7: wrap both ways
    run_one("R7", 8'h05, 0, 0, 0, 16'hFFF0, 32'd3);
    run_one("R7", 8'h05, 0, 0, 0, 16'h0010, 32'hFFFF_FFF8);
    run_one("R7", 8'h15, 0, 1, 2, 16'h0010, 32'hFFFF_FFFF);
    // R8 / R9 / R10
    run_one("R8", 8'h05, 0, 0, 0, 16'h8000, 32'h0001_0000);
    run_one("R9", 8'h85, 0, 0, 0, 16'd30, 32'd50);
    run_one("R9", 8'h85, 1, 0, 0, 16'd30, 32'd50);
    run_one("R9", 8'h86, 2, 0, 0, 16'd30, 32'd50);
    run_one("R10", 8'h95, 0, 0, 0, 16'd30, 32'd50);
    // R11: illegal forms
    run_one("R11", 8'h06, 0, 0, 0, 16'd9, 32'd60);
    run_one("R11", 8'h96, 0, 0, 0, 16'd9, 32'd60);
    run_one("R11", 8'he5, 0, 0, 0, 16'd9, 32'd60);
    run_one("R11", 8'hf6, 0, 0, 0, 16'd9, 32'd60);
    run_one("R11", 8'h85, 3, 0, 0, 16'd9, 32'd60);
    run_one("R11", 8'h0d, 0, 0, 0, 16'd9, 32'd60);
    run_one("R11", 8'h14, 0, 5, 5, 16'd9, 32'd60);

    // R2: idle cycle drops out_valid, outputs hold
    in_valid = 0;
    @(negedge clk);
    expect_bit("R2", "out_valid idle", out_valid, 0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  op;
      logic [3:0]  sf;
      logic [63:0] d, s;
      int          pick;
      op = 8'($urandom);
      pick = $urandom_range(0, 9);
      if (pick < 8) op[2:0] = (pick < 4) ? 3'd5 : 3'd6;
      sf = 4'($urandom_range(0, 4));
      d = {$urandom, $urandom};
      s = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: s = d;
        1: s = {~d[63:32], d[31:0]};
        2: s = d + 64'd1;
        default: ;
      endcase
      run_one(tag_of(op, sf), op, sf, d, s, 16'($urandom), $urandom);
    end

    in_valid = 0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule